// File: doc/BRIEF.md
# Write-Through Invalidating Snoop Cache Controller

This block sits between one processor and a shared bus in a small multiprocessor. It holds a direct-mapped set of single-word lines, each carrying one validity bit. Loads that find a valid matching line are answered locally. Loads that miss fetch the word over the bus and fill the line. Every store goes out on the bus as a write. A store updates the local copy only when that copy is already valid. A store that misses never allocates a line.

A separate snoop port sees every bus write. When another master writes a word that this controller holds, the matching line drops to invalid during that transaction. Bus writes tagged with this controller's own master number are ignored, so its own stores do not invalidate its own copies.

The processor has a one-outstanding-operation handshake. A request is taken only while `cpu_busy` is low. `cpu_done` pulses when the operation finishes.

The controller is a four-state machine:
- `ST_IDLE`: accept a request.
- `ST_BUS_RD`: bus read in flight.
- `ST_BUS_WR`: bus write in flight.
- `ST_RESP`: completion pulse.

Named transitions:
- `IDLE→RESP`: read hit.
- `IDLE→BUS_RD`: read miss.
- `IDLE→BUS_WR`: any store.
- `BUS_RD→RESP`: on `bus_ack`, fill.
- `BUS_WR→RESP`: on `bus_ack`, update the copy if it is valid.
- `RESP→IDLE`: always.

Top module: `wt_snoop_cache`

## Requirements
- R1: Reset leaves every line invalid and holds `cpu_busy`, `cpu_done` and `bus_req` low; the first read of any address after reset uses the bus.
- R2: A read accepted in idle that hits a valid line with a matching tag raises `cpu_done` in the very next cycle with the cached word on `cpu_rdata`, and raises no bus request.
- R3: A read that misses raises `bus_req` with `bus_we`=0 and `bus_addr` equal to the requested address in the cycle after acceptance. The cycle after `bus_ack` shows `cpu_done` with the returned word, and the line then holds that word. Addresses are byte addresses: the index is bits [5:2] and the tag is bits [31:6].
- R4: Every store, hit or miss, raises `bus_req` with `bus_we`=1, carrying the store address and data, in the cycle after acceptance. `cpu_done` follows in the cycle after `bus_ack`.
- R5: A store to a valid matching line updates the local word and keeps the line valid, so a later read hits and returns the stored data.
- R6: A store to an invalid line does not allocate it, so a later read of that address misses.
- R7: A snooped write (`snp_valid`=1, `snp_we`=1) from a master number other than `MY_ID`, to a word held valid, invalidates that line.
- R8: Snooped reads, and snooped writes to a word not held (same index but a different tag), leave the cached line valid.
- R9: Snooped writes carrying this controller's own master number (`snp_mid`=`MY_ID`) are ignored.
- R10: When an invalidating snoop to the same line coincides with the acceptance of a read that would hit, the invalidation wins and the read is handled as a miss over the bus.
- R11: While `bus_req` is high and `bus_ack` is low, `bus_we`, `bus_addr` and `bus_wdata` stay stable and `cpu_busy` stays high. A `cpu_req` raised while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor operation request, taken when not busy |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address of the word |
| cpu_wdata | input | DATA_W | Store data |
| cpu_busy | output | 1 | An operation is in progress |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Load result, valid with `cpu_done` |
| bus_req | output | 1 | Bus transaction request, held until acknowledged |
| bus_we | output | 1 | 1 = bus write, 0 = bus read |
| bus_addr | output | ADDR_W | Transaction byte address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_mid | output | MID_W | This controller's master number |
| bus_ack | input | 1 | Transaction complete; read data valid |
| bus_rdata | input | DATA_W | Bus read data |
| snp_valid | input | 1 | A bus transaction is visible this cycle |
| snp_we | input | 1 | The visible transaction is a write |
| snp_addr | input | ADDR_W-2 | Word address of the visible transaction |
| snp_mid | input | MID_W | Master number of the visible transaction |

## Verification
The two functions that can fall in one cycle are a snoop invalidation and the lookup of a processor read to the same line.

The bench first fills a line. It then raises a load request to that word and, in the same cycle, a foreign snooped write to it, with its memory model changed to the new value.

The result is judged at the ports. A bus read must appear, and the returned data must be the new value rather than the stale cached word. A following read must then hit.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_BUS_RD = 2'd1,
        ST_BUS_WR = 2'd2,
        ST_RESP   = 2'd3
    } wtc_state_e;
endpackage

// File: rtl/wtc_line_store.sv
// Direct-mapped tag/valid/data storage with one processor lookup port,
// one snoop lookup port, an invalidate strobe and a fill/update strobe.
module wtc_line_store #(
    parameter int LINES  = 16,
    parameter int TAG_W  = 26,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    input  logic [IDX_W-1:0]  sn_idx,
    input  logic [TAG_W-1:0]  sn_tag,
    output logic              sn_present,
    input  logic              inv_en,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    logic [LINES-1:0]  valid_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    // Invalidate first, then fill: a fill in the same cycle wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            for (int i = 0; i < LINES; i++) begin
                if (inv_en && sn_idx == IDX_W'(i)) valid_q[i] <= 1'b0;
                if (wr_en && wr_idx == IDX_W'(i))  valid_q[i] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < LINES; i++) begin
            if (wr_en && wr_idx == IDX_W'(i)) begin
                tag_q[i]  <= wr_tag;
                data_q[i] <= wr_data;
            end
        end
    end

    always_comb begin
        lk_hit     = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
        lk_data    = data_q[lk_idx];
        sn_present = valid_q[sn_idx] && (tag_q[sn_idx] == sn_tag);
    end
endmodule

// File: rtl/wtc_snoop_filter.sv
// Decides whether a visible bus transaction must invalidate a local line.
module wtc_snoop_filter #(
    parameter int MID_W = 2,
    parameter logic [MID_W-1:0] MY_ID = '0
) (
    input  logic             snp_valid,
    input  logic             snp_we,
    input  logic [MID_W-1:0] snp_mid,
    input  logic             sn_present,
    output logic             inv_en
);
    always_comb begin
        inv_en = snp_valid && snp_we && (snp_mid != MY_ID) && sn_present;
    end
endmodule

// File: rtl/wtc_ctrl.sv
// Controller state machine: accepts processor operations and sequences
// bus reads, bus writes and the completion pulse.
module wtc_ctrl
    import wtc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              hit,
    input  logic [DATA_W-1:0] hit_data,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    output wtc_state_e        state,
    output logic              idle,
    output logic [ADDR_W-1:0] addr_q,
    output logic              cpu_busy,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              fill_en,
    output logic [DATA_W-1:0] fill_data
);
    wtc_state_e        state_q, state_d;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (cpu_we)   state_d = ST_BUS_WR;
                    else if (hit) state_d = ST_RESP;
                    else          state_d = ST_BUS_RD;
                end
            end
            ST_BUS_RD: if (bus_ack) state_d = ST_RESP;
            ST_BUS_WR: if (bus_ack) state_d = ST_RESP;
            ST_RESP:   state_d = ST_IDLE;
        endcase
    end

    // Operation registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (state_q == ST_IDLE && cpu_req) begin
                addr_q  <= cpu_addr;
                wdata_q <= cpu_wdata;
                if (!cpu_we && hit) rdata_q <= hit_data;
            end
            if (state_q == ST_BUS_RD && bus_ack) rdata_q <= bus_rdata;
        end
    end

    // Outputs
    always_comb begin
        state     = state_q;
        idle      = (state_q == ST_IDLE);
        cpu_busy  = (state_q != ST_IDLE);
        cpu_done  = (state_q == ST_RESP);
        cpu_rdata = rdata_q;
        bus_req   = (state_q == ST_BUS_RD) || (state_q == ST_BUS_WR);
        bus_we    = (state_q == ST_BUS_WR);
        bus_wdata = wdata_q;
        fill_en   = ((state_q == ST_BUS_RD) && bus_ack)
                 || ((state_q == ST_BUS_WR) && bus_ack && hit);
        fill_data = (state_q == ST_BUS_RD) ? bus_rdata : wdata_q;
    end
endmodule

// File: rtl/wt_snoop_cache.sv
module wt_snoop_cache
    import wtc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LINES  = 16,
    parameter int MID_W  = 2,
    parameter logic [MID_W-1:0] MY_ID = 2'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_busy,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic [MID_W-1:0]  bus_mid,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic              snp_we,
    input  logic [ADDR_W-3:0] snp_addr,
    input  logic [MID_W-1:0]  snp_mid
);
    localparam int IDX_W = $clog2(LINES);
    localparam int OFF_W = $clog2(DATA_W / 8);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    wtc_state_e        state;
    logic              idle_w;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] lk_addr;
    logic [IDX_W-1:0]  lk_idx, sn_idx;
    logic [TAG_W-1:0]  lk_tag, sn_tag;
    logic              lk_hit, sn_present, inv_en, kill_w, hit_eff;
    logic [DATA_W-1:0] lk_data;
    logic              fill_en;
    logic [DATA_W-1:0] fill_data;
    logic [ADDR_W-1:0] snp_byte;

    assign snp_byte = {snp_addr, 2'b00};
    assign lk_addr  = idle_w ? cpu_addr : addr_q;
    assign lk_idx   = lk_addr[OFF_W +: IDX_W];
    assign lk_tag   = lk_addr[ADDR_W-1 -: TAG_W];
    assign sn_idx   = snp_byte[OFF_W +: IDX_W];
    assign sn_tag   = snp_byte[ADDR_W-1 -: TAG_W];
    // A same-cycle invalidation of the looked-up line turns a hit into a miss.
    assign kill_w   = inv_en && (sn_idx == lk_idx);
    assign hit_eff  = lk_hit && !kill_w;
    assign bus_addr = addr_q;
    assign bus_mid  = MY_ID;

    wtc_line_store #(
        .LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_hit(lk_hit), .lk_data(lk_data),
        .sn_idx(sn_idx), .sn_tag(sn_tag), .sn_present(sn_present),
        .inv_en(inv_en),
        .wr_en(fill_en), .wr_idx(lk_idx), .wr_tag(lk_tag), .wr_data(fill_data)
    );

    wtc_snoop_filter #(
        .MID_W(MID_W), .MY_ID(MY_ID)
    ) u_snoop (
        .snp_valid(snp_valid), .snp_we(snp_we), .snp_mid(snp_mid),
        .sn_present(sn_present), .inv_en(inv_en)
    );

    wtc_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata),
        .hit(hit_eff), .hit_data(lk_data),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .state(state), .idle(idle_w), .addr_q(addr_q),
        .cpu_busy(cpu_busy), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .fill_en(fill_en), .fill_data(fill_data)
    );
endmodule

// File: rtl/wtc_checker.sv
module wtc_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              idle_w,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic              cpu_done,
    input logic              cpu_busy,
    input logic              hit_eff,
    input logic              kill_w,
    input logic              bus_req,
    input logic              bus_we,
    input logic              bus_ack,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata
);
    a_r2_hit_local: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_w && cpu_req && !cpu_we && hit_eff) |=> (cpu_done && !bus_req));

    a_r3_miss_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_w && cpu_req && !cpu_we && !hit_eff) |=> (bus_req && !bus_we));

    a_r4_store_on_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_w && cpu_req && cpu_we) |=> (bus_req && bus_we));

    a_r10_kill_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_w && cpu_req && !cpu_we && kill_w) |=> (bus_req && !cpu_done));

    a_r11_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && cpu_busy && $stable(bus_addr)
                                   && $stable(bus_we) && $stable(bus_wdata)));
endmodule

bind wt_snoop_cache wtc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .idle_w(idle_w), .cpu_req(cpu_req),
    .cpu_we(cpu_we), .cpu_done(cpu_done), .cpu_busy(cpu_busy),
    .hit_eff(hit_eff), .kill_w(kill_w), .bus_req(bus_req), .bus_we(bus_we),
    .bus_ack(bus_ack), .bus_addr(bus_addr), .bus_wdata(bus_wdata)
);

// File: tb/tb_wt_snoop_cache.sv
module tb_wt_snoop_cache;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] OWN   = 2'd1;
    localparam logic [1:0] OTHER = 2'd2;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        cpu_req = 0, cpu_we = 0;
    logic [31:0] cpu_addr = 0, cpu_wdata = 0;
    logic        cpu_busy, cpu_done;
    logic [31:0] cpu_rdata;
    logic        bus_req, bus_we;
    logic [31:0] bus_addr, bus_wdata;
    logic [1:0]  bus_mid;
    logic        bus_ack = 0;
    logic [31:0] bus_rdata = 0;
    logic        snp_valid = 0, snp_we = 0;
    logic [29:0] snp_addr = 0;
    logic [1:0]  snp_mid = 0;

    int checks = 0, fails = 0;
    bit finished = 0;
    logic [31:0] mem [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    wt_snoop_cache #(.MY_ID(OWN)) dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_busy(cpu_busy),
        .cpu_done(cpu_done), .cpu_rdata(cpu_rdata), .bus_req(bus_req),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_mid(bus_mid), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .snp_valid(snp_valid), .snp_we(snp_we), .snp_addr(snp_addr),
        .snp_mid(snp_mid)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One processor operation with an immediate-ack bus model.
    task automatic cpu_op(input bit we, input logic [31:0] a, input logic [31:0] wd,
                          output logic [31:0] rd, output bit used, output bit wr);
        @(negedge clk);
        cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 0;
        used = 0; wr = 0; rd = '0;
        for (int i = 0; i < 20; i++) begin
            if (cpu_done) begin
                rd = cpu_rdata;
                break;
            end
            if (bus_req) begin
                used = 1; wr = bus_we;
                chk(bus_addr == a, "R3/R4 bus address", bus_addr, a);
                if (bus_we) mem[a[9:2]] = bus_wdata;
                else        bus_rdata = mem[a[9:2]];
                bus_ack = 1;
                @(negedge clk);
                bus_ack = 0;
            end else begin
                @(negedge clk);
            end
        end
    endtask

    task automatic snoop(input logic [31:0] a, input bit we, input logic [1:0] mid,
                         input logic [31:0] val);
        @(negedge clk);
        snp_valid = 1; snp_we = we; snp_addr = a[31:2]; snp_mid = mid;
        if (we && mid != OWN) mem[a[9:2]] = val;
        @(negedge clk);
        snp_valid = 0; snp_we = 0;
    endtask

    task automatic t_reset();
        chk(!cpu_busy, "R1 busy after reset", 32'(cpu_busy), 0);
        chk(!cpu_done, "R1 done after reset", 32'(cpu_done), 0);
        chk(!bus_req, "R1 bus_req after reset", 32'(bus_req), 0);
    endtask

    task automatic t_read_miss_hit();
        logic [31:0] rd; bit used, wr;
        cpu_op(0, 32'h10, 0, rd, used, wr);
        chk(used && !wr, "R1 R3 first read uses bus read", 32'(used), 1);
        chk(rd == mem[4], "R3 miss data", rd, mem[4]);
        cpu_op(0, 32'h10, 0, rd, used, wr);
        chk(!used, "R2 hit uses no bus", 32'(used), 0);
        chk(rd == mem[4], "R2 hit data", rd, mem[4]);
        // Same index, different tag evicts
        cpu_op(0, 32'h50, 0, rd, used, wr);
        chk(used && rd == mem[8'h14], "R3 tag conflict miss", rd, mem[8'h14]);
        cpu_op(0, 32'h10, 0, rd, used, wr);
        chk(used, "R3 evicted line misses", 32'(used), 1);
    endtask

    task automatic t_write_hit();
        logic [31:0] rd; bit used, wr;
        cpu_op(1, 32'h10, 32'hAAAA_5555, rd, used, wr);
        chk(used && wr, "R4 write hit goes to bus", 32'(wr), 1);
        chk(mem[4] == 32'hAAAA_5555, "R4 bus write data", mem[4], 32'hAAAA_5555);
        cpu_op(0, 32'h10, 0, rd, used, wr);
        chk(!used, "R5 read after write hit stays hit", 32'(used), 0);
        chk(rd == 32'hAAAA_5555, "R5 updated local copy", rd, 32'hAAAA_5555);
    endtask

    task automatic t_write_miss();
        logic [31:0] rd; bit used, wr;
        cpu_op(1, 32'h24, 32'h1234_5678, rd, used, wr);
        chk(used && wr, "R4 write miss goes to bus", 32'(wr), 1);
        cpu_op(0, 32'h24, 0, rd, used, wr);
        chk(used, "R6 no allocate on write miss", 32'(used), 1);
        chk(rd == 32'h1234_5678, "R6 read returns memory value", rd, 32'h1234_5678);
    endtask

    task automatic t_snoop_other();
        logic [31:0] rd; bit used, wr;
        cpu_op(0, 32'h30, 0, rd, used, wr);
        snoop(32'h30, 1, OTHER, 32'hBEEF_0001);
        cpu_op(0, 32'h30, 0, rd, used, wr);
        chk(used, "R7 foreign write invalidates", 32'(used), 1);
        chk(rd == 32'hBEEF_0001, "R7 fresh data after invalidate", rd, 32'hBEEF_0001);
    endtask

    task automatic t_snoop_ignored();
        logic [31:0] rd; bit used, wr;
        cpu_op(0, 32'h34, 0, rd, used, wr);
        snoop(32'h74, 1, OTHER, 32'h7777_0000);
        snoop(32'h34, 0, OTHER, 0);
        cpu_op(0, 32'h34, 0, rd, used, wr);
        chk(!used && rd == mem[8'h0D], "R8 unrelated snoops keep line", 32'(used), 0);
        snoop(32'h34, 1, OWN, 0);
        cpu_op(0, 32'h34, 0, rd, used, wr);
        chk(!used, "R9 own-id snoop ignored", 32'(used), 0);
    endtask

    task automatic t_collide();
        logic [31:0] rd; bit used, wr;
        cpu_op(0, 32'h38, 0, rd, used, wr);
        @(negedge clk);
        cpu_req = 1; cpu_we = 0; cpu_addr = 32'h38;
        snp_valid = 1; snp_we = 1; snp_addr = 30'h0E; snp_mid = OTHER;
        mem[8'h0E] = 32'hC011_1DE0;
        @(negedge clk);
        cpu_req = 0; snp_valid = 0; snp_we = 0;
        chk(bus_req && !bus_we && !cpu_done, "R10 collision becomes bus read",
            32'(bus_req), 1);
        bus_rdata = mem[8'h0E]; bus_ack = 1;
        @(negedge clk);
        bus_ack = 0;
        chk(cpu_done && cpu_rdata == 32'hC011_1DE0, "R10 fresh data", cpu_rdata,
            32'hC011_1DE0);
        cpu_op(0, 32'h38, 0, rd, used, wr);
        chk(!used, "R10 line refilled", 32'(used), 0);
    endtask

    task automatic t_hold();
        @(negedge clk);
        cpu_req = 1; cpu_we = 0; cpu_addr = 32'h3C;
        @(negedge clk);
        cpu_req = 0;
        for (int i = 0; i < 3; i++) begin
            if (i == 1) begin cpu_req = 1; cpu_we = 1; cpu_addr = 32'h20; end
            @(negedge clk);
            cpu_req = 0;
            chk(bus_req && !bus_we && bus_addr == 32'h3C && cpu_busy,
                "R11 request held stable", bus_addr, 32'h3C);
        end
        bus_rdata = mem[8'h0F]; bus_ack = 1;
        @(negedge clk);
        bus_ack = 0;
        chk(cpu_done && cpu_rdata == mem[8'h0F], "R11 completes after ack",
            cpu_rdata, mem[8'h0F]);
        @(negedge clk);
        chk(!cpu_busy && !bus_req, "R11 busy request ignored", 32'(bus_req), 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE_0000 + 32'(i * 3);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_read_miss_hit();
        t_write_hit();
        t_write_miss();
        t_snoop_other();
        t_snoop_ignored();
        t_collide();
        t_hold();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule